// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Generator and Checker

This block protects an E1 serial stream with the four-bit cyclic check used on submultiframes. A submultiframe is eight consecutive frames of 256 bits each, so 2048 bits in all. The stream has already been aligned to frames and multiframes, and the position of every bit arrives as a frame index (0..15) and a bit index (0..255). For each submultiframe the block divides the bits, taken first bit first, by the generator x^4 + x + 1 after multiplying them by x^4. The four check-bit positions are read as zero during this division. The remainder is kept for the following submultiframe.

In transmit mode the kept remainder is written into the four check-bit positions of the next submultiframe as the bits pass through. In receive mode the check bits that arrive in the next submultiframe are collected and compared with the kept remainder. A mismatch raises a single-cycle error pulse at the end of that submultiframe. Both functions run only while multiframe alignment is held. A remainder counts only if its whole submultiframe was seen under alignment, so the first submultiframe after alignment is gained is never judged.

The serial input is qualified by `bit_en`, which acts as the valid strobe of the bit stream. There is no ready: a line cannot be stalled, so the block accepts every bit for which `bit_en` is high and never exerts back-pressure. `data_out` is a combinational copy of `data_in` in the same cycle, and it is meaningful only where `bit_en` is high. Searching for alignment and line coding are handled elsewhere.

Top module: `e1_crc4_engine`

## Requirements
- R1: The remainder of a submultiframe is (M(x)·x^4) mod (x^4+x+1). M(x) holds its 2048 bits with the first bit (frame 0 or 8, bit index 0) as the highest power and the last bit (frame 7 or 15, bit index 255) as the lowest. The four check positions count as 0 in M(x).
- R2: The check positions are bit index 0 of the frames whose index modulo 8 is 0, 2, 4 and 6. They carry C1, C2, C3 and C4 in that order, and C1 is the most significant remainder bit.
- R3: When `mode_tx`=1 and `mf_locked`=1 and a remainder is held, `data_out` at each check position equals the matching bit of the previous submultiframe's remainder. With no remainder held, the check positions pass `data_in` unchanged.
- R4: Outside the check positions, and at every position when `mode_tx`=0, `data_out` equals `data_in` in the same cycle.
- R5: When `mode_tx`=0, `crc_err` is high for exactly the one cycle that follows the clock edge that takes the last bit of a judged submultiframe, and only if the four received check bits differ from the held remainder. At every other time `crc_err` is 0.
- R6: A remainder is held only when its whole submultiframe, from the first bit to the last, was received with `mf_locked`=1. Any cycle with `mf_locked`=0 discards the held remainder. No error is reported while unlocked or for the first submultiframe after alignment returns.
- R7: A cycle with `bit_en`=0 changes neither the running division nor the held remainder, and it cannot raise `crc_err`.
- R8: After reset no remainder is held and `crc_err` is 0.
- R9: `crc_err` stays 0 while `mode_tx`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tx | input | 1 | 1 = insert check bits, 0 = verify received check bits |
| mf_locked | input | 1 | Multiframe alignment currently held |
| bit_en | input | 1 | Valid strobe: a stream bit is present this cycle |
| frame_idx | input | 4 | Frame number within the multiframe, 0..15 |
| bit_idx | input | 8 | Bit number within the frame, 0 = first bit |
| data_in | input | 1 | Serial stream bit |
| data_out | output | 1 | Stream bit with check bits inserted (transmit mode) |
| crc_err | output | 1 | One-cycle pulse: check bits of the submultiframe just ended did not match |

## Verification
Two functions share the last bit of every submultiframe. The remainder of the submultiframe that is ending is latched for later use, and in the same cycle the remainder latched one submultiframe earlier is judged against the check bits just received. The bench runs back-to-back submultiframes. The check bits of each one are the bench's own long-division remainder of the one before, XORed with an error mask that sweeps all sixteen values. A correct block flags exactly the nonzero masks, which shows that the comparison still uses the older remainder at the moment it is replaced. A loss of alignment in the middle of a submultiframe then makes the next two verdicts fall silent.

// File: rtl/e1c4_pkg.sv
package e1c4_pkg;
  localparam int CRC_W = 4;
  // Generator x^4 + x + 1 without its leading term.
  localparam logic [CRC_W-1:0] GEN_LOW = 4'b0011;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/e1c4_pos_decode.sv
module e1c4_pos_decode
  import e1c4_pkg::*;
#(
  parameter int SMF_FRAMES = 8,
  parameter int FRAME_BITS = 256,
  parameter int FIDX_W     = $clog2(2 * SMF_FRAMES),
  parameter int BIDX_W     = $clog2(FRAME_BITS)
) (
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic [BIDX_W-1:0] bit_idx,
  output logic              smf_first,
  output logic              smf_last,
  output logic [CRC_W-1:0]  slot_vec
);
  localparam int LOC_W = $clog2(SMF_FRAMES);
  localparam logic [LOC_W-1:0]  LOC_LAST = LOC_W'(SMF_FRAMES - 1);
  localparam logic [BIDX_W-1:0] BIT_LAST = BIDX_W'(FRAME_BITS - 1);

  logic [LOC_W-1:0] loc;
  assign loc       = frame_idx[LOC_W-1:0];
  assign smf_first = (loc == '0) && (bit_idx == '0);
  assign smf_last  = (loc == LOC_LAST) && (bit_idx == BIT_LAST);

  // Check slot k sits at bit 0 of even frame 2k within the submultiframe.
  for (genvar k = 0; k < CRC_W; k++) begin : g_slot
    assign slot_vec[k] = (loc == LOC_W'(2 * k)) && (bit_idx == '0);
  end

  always_comb begin
    AST_ONE_SLOT: assert ($onehot0(slot_vec)); // R2
    AST_SLOT_NOT_LAST: assert (!(smf_last && (|slot_vec))); // R2
  end
endmodule

// File: rtl/e1c4_divider.sv
module e1c4_divider
  import e1c4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  input  logic din,
  output crc_t rem_next
);
  crc_t rem_q;
  crc_t base;
  logic fb;

  always_comb begin
    base     = restart ? '0 : rem_q;
    fb       = din ^ base[CRC_W-1];
    rem_next = {base[CRC_W-2:0], 1'b0} ^ (fb ? GEN_LOW : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rem_q <= '0;
    else if (step)  rem_q <= rem_next;
  end

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(rem_q)); // R7
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (step && restart && !din) |=> (rem_q == '0)); // R1
endmodule

// File: rtl/e1c4_verdict.sv
module e1c4_verdict
  import e1c4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first,
  input  logic             last,
  input  logic [CRC_W-1:0] slot_vec,
  input  logic             data_in,
  input  crc_t             rem_next,
  input  logic             mode_tx,
  input  logic             mf_locked,
  output crc_t             held_rem,
  output logic             held_valid,
  output logic             crc_err
);
  crc_t rx_bits;
  logic clean;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_bits    <= '0;
      clean      <= 1'b0;
      held_rem   <= '0;
      held_valid <= 1'b0;
      crc_err    <= 1'b0;
    end else begin
      crc_err <= 1'b0;
      if (step && first) clean <= mf_locked;
      else               clean <= clean & mf_locked;
      if (step) begin
        for (int k = 0; k < CRC_W; k++)
          if (slot_vec[k]) rx_bits[CRC_W-1-k] <= data_in;
      end
      if (!mf_locked) held_valid <= 1'b0;
      if (step && last) begin
        held_rem   <= rem_next;
        held_valid <= clean & mf_locked;
        crc_err    <= !mode_tx && mf_locked && held_valid && (rx_bits != held_rem);
      end
    end
  end

  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> $past(step && last)); // R5
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> !crc_err); // R5
  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_locked |=> !crc_err); // R6
  AST_TX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_tx |=> !crc_err); // R9
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && mf_locked) |=> $stable(held_rem)); // R7
endmodule

// File: rtl/e1_crc4_engine.sv
module e1_crc4_engine
  import e1c4_pkg::*;
#(
  parameter int SMF_FRAMES = 8,
  parameter int FRAME_BITS = 256,
  parameter int FIDX_W     = $clog2(2 * SMF_FRAMES),
  parameter int BIDX_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tx,
  input  logic              mf_locked,
  input  logic              bit_en,
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic [BIDX_W-1:0] bit_idx,
  input  logic              data_in,
  output logic              data_out,
  output logic              crc_err
);
  logic             smf_first, smf_last;
  logic [CRC_W-1:0] slot_vec;
  logic [CRC_W-1:0] ins_vec;
  crc_t             rem_next, held_rem;
  logic             held_valid;
  logic             in_slot, div_in, ins_en;

  e1c4_pos_decode #(
    .SMF_FRAMES(SMF_FRAMES), .FRAME_BITS(FRAME_BITS),
    .FIDX_W(FIDX_W), .BIDX_W(BIDX_W)
  ) u_pos (
    .frame_idx(frame_idx), .bit_idx(bit_idx),
    .smf_first(smf_first), .smf_last(smf_last), .slot_vec(slot_vec)
  );

  assign in_slot = |slot_vec;
  assign div_in  = in_slot ? 1'b0 : data_in;

  e1c4_divider u_div (
    .clk(clk), .rst_n(rst_n), .step(bit_en), .restart(smf_first),
    .din(div_in), .rem_next(rem_next)
  );

  e1c4_verdict u_verdict (
    .clk(clk), .rst_n(rst_n), .step(bit_en), .first(smf_first),
    .last(smf_last), .slot_vec(slot_vec), .data_in(data_in),
    .rem_next(rem_next), .mode_tx(mode_tx), .mf_locked(mf_locked),
    .held_rem(held_rem), .held_valid(held_valid), .crc_err(crc_err)
  );

  for (genvar k = 0; k < CRC_W; k++) begin : g_ins
    assign ins_vec[k] = slot_vec[k] & held_rem[CRC_W-1-k];
  end

  assign ins_en   = mode_tx && mf_locked && held_valid && in_slot;
  assign data_out = ins_en ? (|ins_vec) : data_in;

  AST_RX_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_tx |-> (data_out == data_in)); // R4
endmodule

// File: tb/tb_e1_crc4_engine.sv
`timescale 1ns/1ps
module tb_e1_crc4_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_tx = 1'b1;
  logic       mf_locked = 1'b1;
  logic       bit_en = 1'b0;
  logic [3:0] frame_idx = '0;
  logic [7:0] bit_idx = '0;
  logic       data_in = 1'b0;
  logic       data_out;
  logic       crc_err;

  always #2.5 clk = ~clk;

  e1_crc4_engine dut (
    .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .mf_locked(mf_locked),
    .bit_en(bit_en), .frame_idx(frame_idx), .bit_idx(bit_idx),
    .data_in(data_in), .data_out(data_out), .crc_err(crc_err)
  );

  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  int unsigned seed = 32'h1234_5678;
  bit          cur[2048];
  bit          work[2052];
  logic [3:0]  prev_rem = '0;
  bit          prev_valid = 1'b0;
  bit          half = 1'b0;

  function automatic bit rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[16];
  endfunction

  // Long division by 1 0 0 1 1 over cur with check positions read as zero.
  function automatic logic [3:0] divide_cur();
    for (int i = 0; i < 2048; i++) work[i] = cur[i];
    for (int i = 2048; i < 2052; i++) work[i] = 1'b0;
    for (int k = 0; k < 4; k++) work[512*k] = 1'b0;
    for (int i = 0; i < 2048; i++)
      if (work[i]) begin
        work[i]   = ~work[i];
        work[i+3] = ~work[i+3];
        work[i+4] = ~work[i+4];
      end
    return {work[2048], work[2049], work[2050], work[2051]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_smf(input bit tx, input logic [3:0] mask,
                          input int drop_from, input int drop_len);
    logic [3:0] new_rem;
    bit exp_ins, clean, err_end, exp_err, exp_out;
    int bad, err_mid, first_bad_act, first_bad_exp;
    for (int i = 0; i < 2048; i++) cur[i] = rnd();
    if (!tx)
      for (int k = 0; k < 4; k++) cur[512*k] = prev_rem[3-k] ^ mask[3-k];
    new_rem = divide_cur();
    exp_ins = tx && prev_valid;
    clean = 1'b1; bad = 0; err_mid = 0; err_end = 1'b0;
    first_bad_act = 0; first_bad_exp = 0;
    for (int i = 0; i < 2048; i++) begin
      if (i % 700 == 350) begin
        // R7: an idle cycle with junk data must not disturb anything.
        @(negedge clk);
        bit_en = 1'b0; data_in = rnd();
        @(posedge clk); #1;
        if (crc_err) err_mid++;
      end
      @(negedge clk);
      bit_en    = 1'b1;
      frame_idx = 4'(int'(half) * 8 + i / 256);
      bit_idx   = 8'(i % 256);
      data_in   = cur[i];
      mf_locked = !(i >= drop_from && i < drop_from + drop_len);
      if (!mf_locked) clean = 1'b0;
      #1;
      exp_out = (exp_ins && (i % 512 == 0)) ? prev_rem[3 - i/512] : cur[i];
      if (data_out !== exp_out) begin
        if (bad == 0) begin first_bad_act = int'(data_out); first_bad_exp = int'(exp_out); end
        bad++;
      end
      @(posedge clk); #1;
      if (i == 2047) err_end = crc_err;
      else if (crc_err) err_mid++;
    end
    mf_locked = 1'b1;
    if (tx) check(bad == 0, "R1/R2/R3 inserted check bits", first_bad_act, first_bad_exp);
    else    check(bad == 0, "R4 receive path transparent", first_bad_act, first_bad_exp);
    exp_err = !tx && prev_valid && clean && (mask != 4'h0);
    if (tx) check(err_end == 1'b0, "R9 no error in transmit", int'(err_end), 0);
    else    check(err_end == exp_err, "R1/R2/R5/R6 verdict at end", int'(err_end), int'(exp_err));
    check(err_mid == 0, "R5/R7 no pulse away from end", err_mid, 0);
    prev_rem   = new_rem;
    prev_valid = clean;
    half       = ~half;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: nothing held after reset, slot passes through, no error.
    frame_idx = 4'd0; bit_idx = 8'd0; data_in = 1'b1; bit_en = 1'b0;
    #1;
    check(data_out == 1'b1, "R8 reset slot passthrough", int'(data_out), 1);
    check(crc_err == 1'b0, "R8 reset error low", int'(crc_err), 0);
    // Transmit: first submultiframe passes through, later ones get inserted bits (R3).
    mode_tx = 1'b1;
    for (int s = 0; s < 5; s++) send_smf(1'b1, 4'h0, -1, 0);
    // Receive: exhaustive sweep over error masks on C1..C4 (R2, R5).
    mode_tx = 1'b0;
    for (int m = 0; m < 16; m++) send_smf(1'b0, 4'(m), -1, 0);
    // R6: alignment drop mid submultiframe silences two verdicts.
    send_smf(1'b0, 4'h5, 300, 10);
    send_smf(1'b0, 4'h9, -1, 0);
    send_smf(1'b0, 4'h3, -1, 0);
    send_smf(1'b0, 4'h0, -1, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule